// File: doc/BRIEF.md
# Peripheral Access Protection Gate

This block sits on the path from a bus master to a row of peripheral register slots. Every access carries a privilege attribute. Each peripheral slot has one "privileged only" bit. When that bit is set and the global enable is high, an unprivileged access to the slot is stopped inside the gate. The peripheral sees no strobe, a blocked read returns zero, and the master gets a `blocked` indication in the same cycle. A blocked access raises a fault flag and records the slot number of the peripheral that was hit. The interrupt line is high while both the flag and its enable are set.

The address is split into a slot index (upper `SLOT_W` bits) and an offset inside the slot (lower `OFF_W` bits). Slots `0 .. NUM_SLOTS-1` are peripherals. Slot `CFG_SLOT` holds the gate's own 32-bit configuration words, selected by word offset:
- 0: control, bit 0 = global enable.
- 1: protection bits for IDs 0..31.
- 2: protection bits for IDs 32..63.
- 3: fault flag, bit 0, read-only.
- 4: interrupt enable, bit 0.
- 5: flag command, write-only (reads 0): bit 0 sets the flag, bit 1 clears it.
- 6: captured fault ID, read-only.

Only privileged masters may reach the configuration slot. Every access completes in one cycle.

Top module: `periph_guard`

## Requirements
- R1: An access that is privileged, or that targets an unprotected slot, is forwarded in the same cycle. `p_valid` is high, `m_blocked` is low, and a read returns `p_rdata` on `m_rdata`.
- R2: While the global enable is 1, an unprivileged access to a protected peripheral slot is blocked. In that cycle `m_blocked` is 1 and `p_valid` and `p_write` are 0.
- R3: A blocked read returns `m_rdata` = 0.
- R4: A blocked access sets the fault flag (word 3, bit 0) by the next cycle. If the flag was 0, it also loads that slot's ID into word 6.
- R5: `irq` is high exactly when the fault flag and the interrupt enable (word 4, bit 0) are both 1. Reading the flag word does not clear it.
- R6: After reset the global enable is 1, all protection bits are 0, the flag is 0, the interrupt enable is 0, and `irq` is low.
- R7: While the global enable is 0, every peripheral access is forwarded whatever its privilege, and no fault is raised.
- R8: While the flag is set, later blocked accesses leave the captured fault ID unchanged.
- R9: A write to word 5 with bit 0 = 1 sets the flag, and one with bit 1 = 1 clears it. When both bits are 1 in the same write, the flag ends up set.
- R10: An unprivileged access to the configuration slot is blocked. A write there changes no configuration state, a read returns 0, and neither raises the fault flag.
- R11: Peripheral ID n < 32 is guarded by bit n of word 1, and ID 32+n by bit n of word 2. Slots at or above `NUM_SLOTS`, other than `CFG_SLOT`, are never protected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| m_valid | input | 1 | Master access strobe, one cycle per access |
| m_write | input | 1 | 1 = write, 0 = read |
| m_priv | input | 1 | 1 = privileged master |
| m_addr | input | SLOT_W+OFF_W | {slot index, offset} |
| m_wdata | input | DATA_W | Write data |
| m_rdata | output | DATA_W | Read data (0 when blocked) |
| m_blocked | output | 1 | Access was intercepted this cycle |
| p_valid | output | 1 | Strobe to the peripheral fabric |
| p_write | output | 1 | Write qualifier to the peripheral fabric |
| p_addr | output | SLOT_W+OFF_W | Address to the peripheral fabric |
| p_wdata | output | DATA_W | Write data to the peripheral fabric |
| p_rdata | input | DATA_W | Read data from the peripheral fabric, same cycle |
| irq | output | 1 | Privilege-fault interrupt |

## Verification
The assertions assume that the master presents at most one access per cycle and holds the address, privilege and write qualifier steady while `m_valid` is high. They also assume that no other agent changes configuration state in the cycle of an unprivileged configuration write. The bench drives every access on the falling edge and keeps it for exactly one rising edge, then drops `m_valid`. It reaches the configuration slot only through ordinary bus accesses, so both assumptions hold throughout the run.

// File: rtl/pg_pkg.sv
package pg_pkg;
   localparam int REG_W     = 32;
   localparam int MAX_SLOTS = 64;

   typedef enum logic [2:0] {
      CFG_CTRL     = 3'd0,
      CFG_PROT_LO  = 3'd1,
      CFG_PROT_HI  = 3'd2,
      CFG_FLAG     = 3'd3,
      CFG_IEN      = 3'd4,
      CFG_FLAG_CMD = 3'd5,
      CFG_FAULT_ID = 3'd6
   } cfg_reg_e;
endpackage

// File: rtl/pg_decode.sv
module pg_decode #(
   parameter int SLOT_W    = 10,
   parameter int OFF_W     = 10,
   parameter int NUM_SLOTS = 64,
   parameter int CFG_SLOT  = 1023,
   parameter int ID_W      = 6,
   localparam int ADDR_W   = SLOT_W + OFF_W
) (
   input  logic [ADDR_W-1:0]              addr,
   input  logic [pg_pkg::MAX_SLOTS-1:0]   prot_vec,
   output logic                           cfg_hit,
   output logic                           prot_hit,
   output logic [ID_W-1:0]                slot_id,
   output logic [OFF_W-1:0]               reg_off
);
   logic [SLOT_W-1:0] slot;
   logic              in_range;
   logic [5:0]        bit_idx;

   always_comb begin
      slot     = addr[ADDR_W-1:OFF_W];
      reg_off  = addr[OFF_W-1:0];
      in_range = (32'(slot) < NUM_SLOTS);
      cfg_hit  = (32'(slot) == CFG_SLOT);
      bit_idx  = 6'(slot);
      slot_id  = ID_W'(slot);
      prot_hit = in_range & prot_vec[bit_idx];
   end
endmodule

// File: rtl/pg_regs.sv
module pg_regs #(
   parameter int OFF_W     = 10,
   parameter int NUM_SLOTS = 64,
   parameter int ID_W      = 6
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic [OFF_W-1:0]              reg_off,
   input  logic [pg_pkg::REG_W-1:0]      wdata,
   input  logic                          fault,
   input  logic [ID_W-1:0]               fault_id,
   output logic [pg_pkg::REG_W-1:0]      rdata,
   output logic                          en_q,
   output logic [pg_pkg::MAX_SLOTS-1:0]  prot_q,
   output logic                          flag_q,
   output logic                          ien_q,
   output logic [ID_W-1:0]               fid_q,
   output logic                          irq
);
   import pg_pkg::*;

   localparam logic [MAX_SLOTS-1:0] PROT_MASK =
      (NUM_SLOTS >= MAX_SLOTS) ? {MAX_SLOTS{1'b1}}
                               : ((64'd1 << NUM_SLOTS) - 64'd1);

   cfg_reg_e          sel;
   logic              sel_ok;
   logic              cmd_wr, sw_set, sw_clr, flag_nxt;
   logic [REG_W-1:0]  hi_rd;

   assign sel    = cfg_reg_e'(reg_off[2:0]);
   assign sel_ok = (reg_off[OFF_W-1:3] == '0) && (reg_off[2:0] != 3'd7);
   assign cmd_wr = wr_en && sel_ok && (sel == CFG_FLAG_CMD);
   assign sw_set = cmd_wr & wdata[0];
   assign sw_clr = cmd_wr & wdata[1];
   // hardware fault or software set dominates a clear in the same cycle
   assign flag_nxt = fault | sw_set | (flag_q & ~sw_clr);

   generate
      if (NUM_SLOTS > REG_W) begin : g_hi_present
         assign hi_rd = prot_q[MAX_SLOTS-1:REG_W];
      end else begin : g_hi_absent
         assign hi_rd = '0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b1;
         prot_q <= '0;
         flag_q <= 1'b0;
         ien_q  <= 1'b0;
         fid_q  <= '0;
      end else begin
         if (wr_en && sel_ok) begin
            case (sel)
               CFG_CTRL:    en_q   <= wdata[0];
               CFG_PROT_LO: prot_q[REG_W-1:0] <= wdata & PROT_MASK[REG_W-1:0];
               CFG_PROT_HI: prot_q[MAX_SLOTS-1:REG_W] <= wdata & PROT_MASK[MAX_SLOTS-1:REG_W];
               CFG_IEN:     ien_q  <= wdata[0];
               default:     ;
            endcase
         end
         flag_q <= flag_nxt;
         if (fault && !flag_q) fid_q <= fault_id;
      end
   end

   always_comb begin
      rdata = '0;
      if (sel_ok) begin
         case (sel)
            CFG_CTRL:     rdata[0] = en_q;
            CFG_PROT_LO:  rdata    = prot_q[REG_W-1:0];
            CFG_PROT_HI:  rdata    = hi_rd;
            CFG_FLAG:     rdata[0] = flag_q;
            CFG_IEN:      rdata[0] = ien_q;
            CFG_FAULT_ID: rdata[ID_W-1:0] = fid_q;
            default:      rdata    = '0;
         endcase
      end
   end

   assign irq = flag_q & ien_q;
endmodule

// File: rtl/periph_guard.sv
module periph_guard #(
   parameter int SLOT_W    = 10,
   parameter int OFF_W     = 10,
   parameter int DATA_W    = 32,
   parameter int NUM_SLOTS = 64,
   parameter int CFG_SLOT  = 1023,
   localparam int ADDR_W   = SLOT_W + OFF_W,
   localparam int ID_W     = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              m_valid,
   input  logic              m_write,
   input  logic              m_priv,
   input  logic [ADDR_W-1:0] m_addr,
   input  logic [DATA_W-1:0] m_wdata,
   output logic [DATA_W-1:0] m_rdata,
   output logic              m_blocked,
   output logic              p_valid,
   output logic              p_write,
   output logic [ADDR_W-1:0] p_addr,
   output logic [DATA_W-1:0] p_wdata,
   input  logic [DATA_W-1:0] p_rdata,
   output logic              irq
);
   import pg_pkg::*;

   generate
      if (NUM_SLOTS < 1 || NUM_SLOTS > MAX_SLOTS) begin : g_chk_slots
         $error("periph_guard: NUM_SLOTS must lie in 1..64");
      end
      if (SLOT_W < 6 || OFF_W < 4) begin : g_chk_widths
         $error("periph_guard: SLOT_W >= 6 and OFF_W >= 4 required");
      end
      if (DATA_W < REG_W) begin : g_chk_data
         $error("periph_guard: DATA_W must be at least 32");
      end
      if (CFG_SLOT < NUM_SLOTS || CFG_SLOT >= (1 << SLOT_W)) begin : g_chk_cfg
         $error("periph_guard: CFG_SLOT must be above the peripheral slots");
      end
   endgenerate

   logic                 cfg_hit, prot_hit;
   logic [ID_W-1:0]      slot_id;
   logic [OFF_W-1:0]     reg_off;
   logic [REG_W-1:0]     cfg_rdata;
   logic                 en_q, flag_q, ien_q;
   logic [MAX_SLOTS-1:0] prot_q;
   logic [ID_W-1:0]      fid_q;
   logic                 blk_periph, cfg_deny, cfg_wr;

   pg_decode #(
      .SLOT_W(SLOT_W), .OFF_W(OFF_W), .NUM_SLOTS(NUM_SLOTS),
      .CFG_SLOT(CFG_SLOT), .ID_W(ID_W)
   ) u_decode (
      .addr(m_addr), .prot_vec(prot_q), .cfg_hit(cfg_hit),
      .prot_hit(prot_hit), .slot_id(slot_id), .reg_off(reg_off)
   );

   assign blk_periph = m_valid & en_q & ~m_priv & prot_hit;
   assign cfg_deny   = m_valid & cfg_hit & ~m_priv;
   assign cfg_wr     = m_valid & cfg_hit & m_priv & m_write;

   pg_regs #(
      .OFF_W(OFF_W), .NUM_SLOTS(NUM_SLOTS), .ID_W(ID_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr), .reg_off(reg_off),
      .wdata(m_wdata[REG_W-1:0]), .fault(blk_periph), .fault_id(slot_id),
      .rdata(cfg_rdata), .en_q(en_q), .prot_q(prot_q), .flag_q(flag_q),
      .ien_q(ien_q), .fid_q(fid_q), .irq(irq)
   );

   assign m_blocked = blk_periph | cfg_deny;
   assign p_valid   = m_valid & ~cfg_hit & ~blk_periph;
   assign p_write   = p_valid & m_write;
   assign p_addr    = m_addr;
   assign p_wdata   = m_wdata;

   always_comb begin
      if (m_blocked)    m_rdata = '0;
      else if (cfg_hit) m_rdata = DATA_W'(cfg_rdata);
      else              m_rdata = p_rdata;
   end
endmodule

// File: rtl/periph_guard_chk.sv
module periph_guard_chk #(
   parameter int SLOT_W    = 10,
   parameter int OFF_W     = 10,
   parameter int DATA_W    = 32,
   parameter int NUM_SLOTS = 64,
   parameter int CFG_SLOT  = 1023,
   parameter int ID_W      = 6,
   localparam int ADDR_W   = SLOT_W + OFF_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              m_valid,
   input logic              m_write,
   input logic              m_priv,
   input logic [ADDR_W-1:0] m_addr,
   input logic [DATA_W-1:0] m_rdata,
   input logic              m_blocked,
   input logic              p_valid,
   input logic              irq,
   input logic              en_q,
   input logic [63:0]       prot_q,
   input logic              flag_q,
   input logic              ien_q,
   input logic [ID_W-1:0]   fid_q
);
   logic [SLOT_W-1:0] slot;
   logic              guarded, to_cfg;

   assign slot    = m_addr[ADDR_W-1:OFF_W];
   assign guarded = (32'(slot) < NUM_SLOTS) && prot_q[6'(slot)];
   assign to_cfg  = (32'(slot) == CFG_SLOT);

   assert_blocked_hidden_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (m_valid && en_q && !m_priv && guarded) |-> (m_blocked && !p_valid));

   assert_blocked_read_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (m_blocked && !m_write) |-> (m_rdata == '0));

   assert_fault_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (m_valid && en_q && !m_priv && guarded && !flag_q)
      |=> (flag_q && fid_q == ID_W'($past(slot))));

   assert_irq_needs_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (flag_q && ien_q));

   assert_bypass_when_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (m_valid && !en_q && !to_cfg) |-> (p_valid && !m_blocked));

   assert_id_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && m_valid && en_q && !m_priv && guarded) |=> $stable(fid_q));

   assert_cfg_locked_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (m_valid && to_cfg && !m_priv)
      |=> ($stable(prot_q) && $stable(en_q) && $stable(ien_q) && $stable(flag_q)));
endmodule

bind periph_guard periph_guard_chk #(
   .SLOT_W(SLOT_W), .OFF_W(OFF_W), .DATA_W(DATA_W),
   .NUM_SLOTS(NUM_SLOTS), .CFG_SLOT(CFG_SLOT), .ID_W(ID_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .m_valid(m_valid), .m_write(m_write),
   .m_priv(m_priv), .m_addr(m_addr), .m_rdata(m_rdata),
   .m_blocked(m_blocked), .p_valid(p_valid), .irq(irq), .en_q(en_q),
   .prot_q(prot_q), .flag_q(flag_q), .ien_q(ien_q), .fid_q(fid_q)
);

// File: tb/periph_guard_bench.sv
module periph_guard_bench;
   localparam int SLOT_W = 10;
   localparam int OFF_W  = 10;
   localparam int DATA_W = 32;
   localparam int ADDR_W = SLOT_W + OFF_W;
   localparam logic [9:0] CFG = 10'h3FF;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              m_valid = 1'b0, m_write = 1'b0, m_priv = 1'b0;
   logic [ADDR_W-1:0] m_addr = '0;
   logic [DATA_W-1:0] m_wdata = '0;
   logic [DATA_W-1:0] m_rdata, p_wdata, p_rdata;
   logic              m_blocked, p_valid, p_write, irq;
   logic [ADDR_W-1:0] p_addr;

   int  n_chk = 0;
   int  n_err = 0;
   bit  done  = 0;
   logic        r_blk, r_pv;
   logic [31:0] r_rd;

   always #2 clk = ~clk;   // 250 MHz

   assign p_rdata = 32'h5A00_0000 | 32'(p_addr);

   periph_guard u_periph_guard (
      .clk(clk), .rst_n(rst_n), .m_valid(m_valid), .m_write(m_write),
      .m_priv(m_priv), .m_addr(m_addr), .m_wdata(m_wdata), .m_rdata(m_rdata),
      .m_blocked(m_blocked), .p_valid(p_valid), .p_write(p_write),
      .p_addr(p_addr), .p_wdata(p_wdata), .p_rdata(p_rdata), .irq(irq)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic access(input logic w, input logic pr, input logic [9:0] slot,
                         input logic [9:0] off, input logic [31:0] wd);
      @(negedge clk);
      m_valid = 1'b1; m_write = w; m_priv = pr;
      m_addr = {slot, off}; m_wdata = wd;
      #1;
      r_blk = m_blocked; r_pv = p_valid; r_rd = m_rdata;
      @(posedge clk);
      #1;
      m_valid = 1'b0; m_write = 1'b0;
   endtask

   function automatic logic [31:0] model(input logic [9:0] slot, input logic [9:0] off);
      return 32'h5A00_0000 | 32'({slot, off});
   endfunction

   task automatic cfg_wr(input logic [9:0] off, input logic [31:0] d);
      access(1'b1, 1'b1, CFG, off, d);
   endtask

   task automatic cfg_rd(input logic [9:0] off, output logic [31:0] d);
      access(1'b0, 1'b1, CFG, off, 32'h0);
      d = r_rd;
   endtask

   task automatic t_reset;
      logic [31:0] d;
      cfg_rd(10'd0, d); check("R6 ctrl", d, 32'h1);
      cfg_rd(10'd1, d); check("R6 prot_lo", d, 32'h0);
      cfg_rd(10'd2, d); check("R6 prot_hi", d, 32'h0);
      cfg_rd(10'd3, d); check("R6 flag", d, 32'h0);
      cfg_rd(10'd4, d); check("R6 ien", d, 32'h0);
      check("R6 irq", 32'(irq), 32'h0);
   endtask

   task automatic t_open;
      access(1'b0, 1'b0, 10'd5, 10'd3, 32'h0);
      check("R1 open read pv", 32'(r_pv), 32'h1);
      check("R1 open read data", r_rd, model(10'd5, 10'd3));
      access(1'b1, 1'b0, 10'd7, 10'd0, 32'h1234);
      check("R1 open write pv", 32'(r_pv), 32'h1);
      check("R1 open write blk", 32'(r_blk), 32'h0);
   endtask

   task automatic t_protect;
      logic [31:0] d;
      cfg_wr(10'd1, 32'h0000_0020);
      cfg_wr(10'd2, 32'h0000_0100);
      cfg_rd(10'd1, d); check("R11 lo readback", d, 32'h20);
      cfg_rd(10'd2, d); check("R11 hi readback", d, 32'h100);
      access(1'b0, 1'b1, 10'd5, 10'd1, 32'h0);
      check("R1 privileged passes", r_rd, model(10'd5, 10'd1));
      access(1'b0, 1'b0, 10'd5, 10'd2, 32'h0);
      check("R2 blocked flag", 32'(r_blk), 32'h1);
      check("R2 no strobe", 32'(r_pv), 32'h0);
      check("R3 zero read", r_rd, 32'h0);
      cfg_rd(10'd3, d); check("R4 flag set", d, 32'h1);
      cfg_rd(10'd6, d); check("R4 fault id", d, 32'd5);
      access(1'b1, 1'b0, 10'd40, 10'd0, 32'hFFFF);
      check("R2 blocked write", 32'({r_blk, r_pv}), 32'h2);
      cfg_rd(10'd6, d); check("R8 id held", d, 32'd5);
      access(1'b0, 1'b0, 10'd6, 10'd0, 32'h0);
      check("R11 neighbour slot open", 32'(r_pv), 32'h1);
   endtask

   task automatic t_irq;
      logic [31:0] d;
      check("R5 irq masked", 32'(irq), 32'h0);
      cfg_wr(10'd4, 32'h1);
      @(negedge clk); check("R5 irq on", 32'(irq), 32'h1);
      cfg_rd(10'd3, d);
      cfg_rd(10'd3, d); check("R5 read keeps flag", d, 32'h1);
      cfg_wr(10'd4, 32'h0);
      @(negedge clk); check("R5 irq off", 32'(irq), 32'h0);
   endtask

   task automatic t_clear_recapture;
      logic [31:0] d;
      cfg_wr(10'd5, 32'h2);
      cfg_rd(10'd3, d); check("R9 clear", d, 32'h0);
      access(1'b0, 1'b0, 10'd40, 10'd4, 32'h0);
      check("R11 slot 40 via hi bit 8", 32'(r_blk), 32'h1);
      cfg_rd(10'd6, d); check("R4 recapture", d, 32'd40);
   endtask

   task automatic t_set_wins;
      logic [31:0] d;
      cfg_wr(10'd5, 32'h2);
      cfg_wr(10'd5, 32'h3);
      cfg_rd(10'd3, d); check("R9 set wins", d, 32'h1);
      cfg_wr(10'd5, 32'h2);
      cfg_rd(10'd3, d); check("R9 clear again", d, 32'h0);
      cfg_wr(10'd5, 32'h1);
      cfg_rd(10'd3, d); check("R9 sw set", d, 32'h1);
      cfg_rd(10'd5, d); check("R9 cmd reads zero", d, 32'h0);
      cfg_wr(10'd5, 32'h2);
   endtask

   task automatic t_disable;
      logic [31:0] d;
      cfg_wr(10'd0, 32'h0);
      access(1'b0, 1'b0, 10'd5, 10'd9, 32'h0);
      check("R7 pass when off", r_rd, model(10'd5, 10'd9));
      check("R7 not blocked", 32'(r_blk), 32'h0);
      cfg_rd(10'd3, d); check("R7 no fault", d, 32'h0);
      cfg_wr(10'd0, 32'h1);
   endtask

   task automatic t_cfg_lock;
      logic [31:0] d;
      access(1'b1, 1'b0, CFG, 10'd1, 32'h0);
      check("R10 write blocked", 32'(r_blk), 32'h1);
      access(1'b0, 1'b0, CFG, 10'd0, 32'h0);
      check("R10 read zero", r_rd, 32'h0);
      cfg_rd(10'd1, d); check("R10 prot kept", d, 32'h20);
      cfg_rd(10'd3, d); check("R10 no fault", d, 32'h0);
   endtask

   task automatic t_edges;
      logic [31:0] d;
      cfg_wr(10'd2, 32'h8000_0100);
      access(1'b0, 1'b0, 10'd63, 10'd0, 32'h0);
      check("R11 top slot blocked", 32'(r_blk), 32'h1);
      cfg_rd(10'd6, d); check("R4 id 63", d, 32'd63);
      access(1'b0, 1'b0, 10'd100, 10'd2, 32'h0);
      check("R11 out of range open", r_rd, model(10'd100, 10'd2));
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_open();
      t_protect();
      t_irq();
      t_clear_recapture();
      t_set_wins();
      t_disable();
      t_cfg_lock();
      t_edges();
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end
endmodule